// File: doc/BRIEF.md
# Console Printer Output Controller

This block drives the printer half of a console terminal. A host issues start and stop commands and polls a small status word. While the block is busy it pulls 6-bit character codes from a channel over a request/acknowledge pair. It turns each code into a 7-bit ASCII byte, zero-extended to 8 bits, and offers that byte to a terminal sink over a valid/ready stream. One code stands for "new line" and goes out as two bytes, carriage return and then line feed. When the channel marks a code as the last of its record, the block finishes sending that byte. It then leaves the busy state, records end of transfer and raises a done signal for the host.

The byte stream follows the usual back-pressure rules. Once `tx_valid` is high, it stays high and `tx_byte` holds its value until a cycle in which `tx_ready` is also high; the byte transfers at that clock edge. While a byte waits, the block fetches nothing from the channel. Reading the status with `stat_rd` returns the current word on `stat_word` in that cycle and clears every bit except busy at the following edge. Commands and status reads are single-cycle strobes with no handshake.

Top module: `con_prn_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the status word to zero, deasserts `done` and `tx_valid`, and drops any held byte.
- R2: A command with bit 0 set (start) sets BUSY (status bit 5), clears END (status bit 0) and lets `ch_req` assert so that fetching begins.
- R3: A command with bit 1 set (stop) clears BUSY. After the byte in flight is sent, no further code is requested. When both bits are set, stop wins.
- R4: Any command clears `done`. A stop leaves END unchanged.
- R5: The status word is 6 bits wide. END sits at bit 0 and BUSY at bit 5, and bits 1 to 4 always read zero.
- R6: During a `stat_rd` cycle, `stat_word` shows the full word. At the next edge every bit other than BUSY is cleared, and `done` is cleared with it.
- R7: A code keeps its low 4 bits, and its top 2 bits become the upper 3 bits of the 7-bit result: 00 becomes 011, 01 becomes 010, 10 becomes 100, 11 becomes 101. For example, code 0x00 gives 0x30, 0x10 gives 0x20, 0x20 gives 0x40 and 0x3E gives 0x5E.
- R8: Code 0x3F, whose translation is octal 137, is sent as 0x0D followed directly by 0x0A, and no new code is fetched in between.
- R9: While the sink stalls, the held byte stays on `tx_byte` with `tx_valid` high. `ch_req` stays low while any byte is held.
- R10: When `ch_eor` comes with the acknowledged code, that code's byte (or bytes) is sent first. At the final acceptance, BUSY clears, END sets and `done` rises.
- R11: `ch_req` is high only while BUSY is set and no byte is held. `ch_ack` has no effect while `ch_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_word | input | 2 | Bit 0 start, bit 1 stop |
| stat_rd | input | 1 | Status read strobe (clear on read) |
| stat_word | output | 6 | Status: bit 0 END, bit 5 BUSY |
| done | output | 1 | Transfer-done indication to the host |
| ch_req | output | 1 | Request for the next code from the channel |
| ch_ack | input | 1 | Channel supplies a code this cycle |
| ch_code | input | 6 | Character code from the channel |
| ch_eor | input | 1 | End of record, qualified by `ch_ack` |
| tx_valid | output | 1 | Byte available to the sink |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_byte | output | 8 | ASCII byte to the sink |

## Verification
The translation is driven with codes at both ends of each 16-code group (0x00, 0x0F, 0x10, 0x1F, 0x20, 0x2F, 0x30, 0x3E). A swapped or wrongly widened top-bit mapping therefore shows up as a wrong byte. New-line codes are placed at the start, middle and end of records, once with a sink that is always ready and once with a sink that accepts only every third cycle. This separates a lost or reordered line feed from a byte dropped or repeated under back-pressure. Records that end normally are compared with records cut short by stop, and with acknowledges given while no request is pending, to show that only a requested code moves data.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  parameter int CODE_W   = 6;
  parameter int BYTE_W   = 8;
  parameter int STAT_W   = 6;
  parameter int CMD_W    = 2;
  parameter int END_BIT  = 0;
  parameter int BUSY_BIT = 5;
  parameter int LOW_W    = 4;

  localparam int HI_W = CODE_W - LOW_W;

  localparam logic [BYTE_W-1:0] ASC_CR  = 8'h0D;
  localparam logic [BYTE_W-1:0] ASC_LF  = 8'h0A;
  localparam logic [BYTE_W-1:0] NL_MARK = 8'h5F;

  localparam logic [STAT_W-1:0] BUSY_MASK = STAT_W'(1) << BUSY_BIT;

  typedef enum logic [0:0] {ST_FETCH, ST_SEND} emit_st_t;
endpackage

// File: rtl/cpr_xlate.sv
module cpr_xlate
  import cpr_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [BYTE_W-1:0] ascii,
  output logic              is_nl
);
  logic [2:0]       hi3;
  logic [LOW_W-1:0] lo;

  assign lo = code[LOW_W-1:0];

  always_comb begin
    unique case (code[CODE_W-1 -: HI_W])
      2'b00:   hi3 = 3'b011;
      2'b01:   hi3 = 3'b010;
      2'b10:   hi3 = 3'b100;
      default: hi3 = 3'b101;
    endcase
  end

  assign ascii = BYTE_W'({hi3, lo});
  assign is_nl = (ascii == NL_MARK);
endmodule

// File: rtl/cpr_ctl.sv
module cpr_ctl
  import cpr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              stat_rd,
  input  logic              fin,
  output logic              busy,
  output logic              done,
  output logic [STAT_W-1:0] stat_word
);
  logic [STAT_W-1:0] stat_q, stat_d;
  logic              done_q, done_d;

  always_comb begin
    stat_d = stat_q;
    done_d = done_q;
    if (stat_rd) begin
      stat_d = stat_d & BUSY_MASK;
      done_d = 1'b0;
    end
    if (fin) begin
      stat_d[END_BIT]  = 1'b1;
      stat_d[BUSY_BIT] = 1'b0;
      done_d           = 1'b1;
    end
    if (cmd_valid) begin
      if (cmd_word[0]) stat_d = BUSY_MASK;
      if (cmd_word[1]) stat_d[BUSY_BIT] = 1'b0;
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      done_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      done_q <= done_d;
    end
  end

  assign busy      = stat_q[BUSY_BIT];
  assign done      = done_q;
  assign stat_word = stat_q;
endmodule

// File: rtl/cpr_emit.sv
module cpr_emit
  import cpr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  output logic              ch_req,
  input  logic              ch_ack,
  input  logic [CODE_W-1:0] ch_code,
  input  logic              ch_eor,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              fin
);
  emit_st_t          st;
  logic [BYTE_W-1:0] hold;
  logic              lf_pend;
  logic              eor_q;
  logic [BYTE_W-1:0] xl_byte;
  logic              xl_nl;

  cpr_xlate u_xlate (
    .code  (ch_code),
    .ascii (xl_byte),
    .is_nl (xl_nl)
  );

  assign ch_req   = busy && (st == ST_FETCH);
  assign tx_valid = (st == ST_SEND);
  assign tx_byte  = hold;
  assign fin      = tx_valid && tx_ready && !lf_pend && eor_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_FETCH;
      hold    <= '0;
      lf_pend <= 1'b0;
      eor_q   <= 1'b0;
    end else begin
      unique case (st)
        ST_FETCH: begin
          if (ch_req && ch_ack) begin
            hold    <= xl_nl ? ASC_CR : xl_byte;
            lf_pend <= xl_nl;
            eor_q   <= ch_eor;
            st      <= ST_SEND;
          end
        end
        default: begin
          if (tx_ready) begin
            if (lf_pend) begin
              hold    <= ASC_LF;
              lf_pend <= 1'b0;
            end else begin
              eor_q <= 1'b0;
              st    <= ST_FETCH;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/con_prn_ctrl.sv
module con_prn_ctrl
  import cpr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] stat_word,
  output logic              done,
  output logic              ch_req,
  input  logic              ch_ack,
  input  logic [CODE_W-1:0] ch_code,
  input  logic              ch_eor,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_byte
);
  logic busy;
  logic fin;

  cpr_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .stat_rd   (stat_rd),
    .fin       (fin),
    .busy      (busy),
    .done      (done),
    .stat_word (stat_word)
  );

  cpr_emit u_emit (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .ch_req   (ch_req),
    .ch_ack   (ch_ack),
    .ch_code  (ch_code),
    .ch_eor   (ch_eor),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_byte  (tx_byte),
    .fin      (fin)
  );
endmodule

// File: rtl/con_prn_ctrl_chk.sv
module con_prn_ctrl_chk
  import cpr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [CMD_W-1:0]  cmd_word,
  input logic              stat_rd,
  input logic [STAT_W-1:0] stat_word,
  input logic              done,
  input logic              ch_req,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [BYTE_W-1:0] tx_byte
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (stat_word == '0) && !done && !tx_valid);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_word == 2'b01) |=> stat_word[BUSY_BIT] && !stat_word[END_BIT] && !done);

  assert_stop_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_word[1]) |=> !stat_word[BUSY_BIT] && !done);

  assert_spare_zero_R5: assert property (@(posedge clk) disable iff (rst)
    stat_word[BUSY_BIT-1:END_BIT+1] == '0);

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !cmd_valid && !(tx_valid && tx_ready))
      |=> ((stat_word & ~BUSY_MASK) == '0) && !done);

  assert_cr_then_lf_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && tx_byte == ASC_CR) |=> tx_valid && tx_byte == ASC_LF);

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_byte));

  assert_no_fetch_held_R9: assert property (@(posedge clk) disable iff (rst)
    !(ch_req && tx_valid));

  assert_done_end_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> stat_word[END_BIT] && !stat_word[BUSY_BIT]);

  assert_req_busy_R11: assert property (@(posedge clk) disable iff (rst)
    ch_req |-> stat_word[BUSY_BIT]);
endmodule

bind con_prn_ctrl con_prn_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_word  (cmd_word),
  .stat_rd   (stat_rd),
  .stat_word (stat_word),
  .done      (done),
  .ch_req    (ch_req),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_byte   (tx_byte)
);

// File: tb/con_prn_ctrl_bench.sv
module con_prn_ctrl_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_word = 2'b00;
  logic       stat_rd = 1'b0;
  logic [5:0] stat_word;
  logic       done;
  logic       ch_req;
  logic       ch_ack = 1'b0;
  logic [5:0] ch_code = '0;
  logic       ch_eor = 1'b0;
  logic       tx_valid;
  logic       tx_ready = 1'b0;
  logic [7:0] tx_byte;

  con_prn_ctrl u_con_prn_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .stat_rd(stat_rd), .stat_word(stat_word), .done(done),
    .ch_req(ch_req), .ch_ack(ch_ack), .ch_code(ch_code), .ch_eor(ch_eor),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic [5:0] q [0:31];
  int         q_len = 0;
  int         q_idx = 0;
  logic [7:0] rx_log [0:63];
  int         rx_n = 0;
  logic       slow = 1'b0;
  logic       ack_force = 1'b0;
  int         stall_ctr = 0;
  int         hold_bad = 0;
  logic       pa = 0, preq = 0, pv = 0, pr = 0;
  logic [7:0] pb = '0;

  // channel and sink models, all driven at the falling edge
  always @(negedge clk) begin
    if (pa && preq) q_idx = q_idx + 1;
    if (pv && pr) begin
      if (rx_n < 64) rx_log[rx_n] = pb;
      rx_n = rx_n + 1;
    end
    if (pv && !pr && tx_valid && tx_byte != pb) hold_bad = hold_bad + 1;
    if (ch_req && tx_valid) hold_bad = hold_bad + 1;
    stall_ctr = (stall_ctr == 2) ? 0 : stall_ctr + 1;
    tx_ready  = slow ? (stall_ctr == 2) : 1'b1;
    ch_ack    = ack_force || (ch_req && q_idx < q_len);
    ch_code   = ack_force ? 6'h3F : ((q_idx < 32) ? q[q_idx] : 6'h00);
    ch_eor    = ack_force || (q_idx == q_len - 1);
    pa = ch_ack; preq = ch_req; pv = tx_valid; pr = tx_ready; pb = tx_byte;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] xl(input logic [5:0] c);
    logic [2:0] h;
    case (c[5:4])
      2'b00: h = 3'b011;
      2'b01: h = 3'b010;
      2'b10: h = 3'b100;
      default: h = 3'b101;
    endcase
    return {1'b0, h, c[3:0]};
  endfunction

  task automatic do_cmd(input logic [1:0] w);
    @(negedge clk); cmd_valid = 1'b1; cmd_word = w;
    @(negedge clk); cmd_valid = 1'b0; cmd_word = 2'b00;
  endtask

  task automatic do_read(input logic [5:0] exp_before, input string req);
    @(negedge clk); stat_rd = 1'b1;
    #1 chk(stat_word == exp_before, req, stat_word, exp_before);
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 600 && !done; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic cmp_log(input string req);
    logic [7:0] e [0:63];
    int en = 0;
    for (int i = 0; i < q_len; i++) begin
      if (xl(q[i]) == 8'h5F) begin e[en] = 8'h0D; e[en+1] = 8'h0A; en += 2; end
      else begin e[en] = xl(q[i]); en++; end
    end
    chk(rx_n == en, req, rx_n, en);
    for (int i = 0; i < en && i < rx_n; i++)
      chk(rx_log[i] == e[i], req, rx_log[i], e[i]);
  endtask

  task automatic load_q(input logic [5:0] c [], input logic s);
    @(posedge clk);
    foreach (c[i]) q[i] = c[i];
    q_len = c.size(); q_idx = 0; rx_n = 0; slow = s;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(stat_word == 6'h00, "R1 status", stat_word, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
    chk(ch_req == 1'b0, "R1 ch_req", ch_req, 0);
  endtask

  task automatic t_xlate();
    load_q('{6'h00, 6'h0F, 6'h10, 6'h1F, 6'h20, 6'h2F, 6'h30, 6'h3E}, 1'b0);
    do_cmd(2'b01);
    wait_done();
    cmp_log("R7 translation");
    chk(stat_word == 6'h01, "R10 END set BUSY clear (R5 layout)", stat_word, 6'h01);
    chk(done == 1'b1, "R10 done", done, 1);
  endtask

  task automatic t_cmd_done();
    do_cmd(2'b10);
    chk(done == 1'b0, "R4 command clears done", done, 0);
    chk(stat_word == 6'h01, "R4 stop keeps END", stat_word, 6'h01);
    do_read(6'h01, "R6 read returns full word");
    chk(stat_word == 6'h00, "R6 cleared after read", stat_word, 0);
  endtask

  task automatic t_crlf();
    load_q('{6'h01, 6'h3F, 6'h02, 6'h3F}, 1'b0);
    do_cmd(2'b01);
    wait_done();
    cmp_log("R8 newline expansion");
    do_read(6'h01, "R10 END after newline record");
    chk(done == 1'b0, "R6 read clears done", done, 0);
  endtask

  task automatic t_stall();
    hold_bad = 0;
    load_q('{6'h3F, 6'h05, 6'h3F, 6'h2A, 6'h11}, 1'b1);
    do_cmd(2'b01);
    wait_done();
    cmp_log("R9 slow sink");
    chk(hold_bad == 0, "R9 stable hold and no fetch", hold_bad, 0);
    chk(stat_word == 6'h01, "R10 END under stall", stat_word, 6'h01);
  endtask

  task automatic t_busy_read();
    load_q('{6'h00}, 1'b0);
    @(posedge clk); q_len = 0;
    do_cmd(2'b01);
    chk(stat_word == 6'h20, "R2 start sets BUSY clears END", stat_word, 6'h20);
    chk(ch_req == 1'b1, "R2 fetch requested", ch_req, 1);
    do_read(6'h20, "R6 read while busy");
    chk(stat_word == 6'h20, "R6 BUSY kept", stat_word, 6'h20);
    do_cmd(2'b11);
    chk(stat_word == 6'h00, "R3 start+stop leaves idle", stat_word, 0);
    chk(ch_req == 1'b0, "R3 no request", ch_req, 0);
  endtask

  task automatic t_stop();
    int snap;
    load_q('{6'h01, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07, 6'h08,
             6'h09, 6'h0A, 6'h0B, 6'h0C}, 1'b0);
    do_cmd(2'b01);
    repeat (4) @(negedge clk);
    do_cmd(2'b10);
    repeat (3) @(negedge clk);
    snap = q_idx;
    repeat (20) @(negedge clk);
    chk(q_idx == snap, "R3 no fetch after stop", q_idx, snap);
    chk(q_idx < 12, "R3 record cut short", q_idx, 12);
    chk(stat_word == 6'h00, "R3 BUSY clear", stat_word, 0);
    chk(done == 1'b0, "R3 no done", done, 0);
    @(posedge clk); ack_force = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      #1 chk(tx_valid == 1'b0, "R11 ack ignored without request", tx_valid, 0);
    end
    @(posedge clk); ack_force = 1'b0;
    repeat (2) @(negedge clk);
    chk(stat_word == 6'h00 && done == 1'b0, "R11 state untouched", stat_word, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_xlate();
    t_cmd_done();
    t_crlf();
    t_stall();
    t_busy_read();
    t_stop();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule